// File: doc/BRIEF.md
# Transmit Event Log FIFO

This block keeps a record of every frame that the transmit path has finished sending. The host reads those records back in the order the frames left. When the transmit path signals completion, the block takes one element and stores three things in it: the identifier of the finished frame, the value of a free-running timestamp input in that cycle, and the marker byte copied from the buffer that held the frame. The host uses the marker to tie each event back to the buffer it queued.

The host pops elements one at a time. Each pop returns the oldest element in the following cycle, with a valid strobe. The block reports its fill level and full and empty flags. It raises a one-cycle watermark interrupt when the fill level climbs to a programmable threshold, so the host can drain the log before it overflows. A completion that arrives while the log is full is dropped and sets a sticky overflow flag, which the host clears. The usable depth can be configured from 1 up to the storage depth, and the read and write indices wrap at that configured depth.

Top module: `txevt_log`

## Requirements
- R1: While reset is held and after it is released, fill_o is 0, empty_o is 1, full_o is 0, and rd_vld_o, wm_irq_o and ovf_o are all 0.
- R2: A cycle with done_i high and room in the log stores {done_id_i, ts_i, done_mrk_i} as sampled in that cycle. fill_o shows the count one higher in the next cycle.
- R3: A cycle with pop_i high while the log is not empty gives rd_vld_o = 1 in the next cycle, with rd_id_o, rd_ts_o and rd_mrk_o equal to the oldest stored element. Elements leave in the order they were stored.
- R4: The effective depth is cfg_size_i, with 0 read as 1 and any value above DEPTH read as DEPTH. fill_o never exceeds the effective depth, and full_o is 1 exactly when fill_o equals it.
- R5: The write and read indices wrap at the effective depth, so order and contents stay correct over many passes through the log at every configured depth.
- R6: Both a pop and a completion in the same cycle on a non-empty log, including a full one, leave fill_o unchanged. The pop returns the oldest element, the new element is stored, and no overflow is flagged.
- R7: A completion while the log is full with no pop in the same cycle is dropped. ovf_o goes to 1, fill_o is unchanged, and the stored elements are read back unchanged later.
- R8: A pop on an empty log is ignored: rd_vld_o stays 0 in the next cycle. If a completion arrives in that same cycle, it is still stored.
- R9: wm_irq_o is 1 for exactly the one cycle in which fill_o first shows a value equal to a non-zero cfg_wm_i after a rise. A threshold of 0 never raises it.
- R10: ovf_o stays 1 until a cycle with ovf_clr_i high clears it. A drop in the same cycle as the clear wins, and ovf_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_i | input | CW | Configured depth (0 read as 1, clamped to DEPTH) |
| cfg_wm_i | input | CW | Watermark threshold, 0 disables |
| ts_i | input | TS_W | Free-running timestamp |
| done_i | input | 1 | Transmit completion pulse |
| done_id_i | input | ID_W | Identifier of the finished frame |
| done_mrk_i | input | MRK_W | Marker of the sent buffer |
| pop_i | input | 1 | Host pop request |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| rd_vld_o | output | 1 | Popped element valid |
| rd_id_o | output | ID_W | Popped identifier |
| rd_ts_o | output | TS_W | Popped timestamp |
| rd_mrk_o | output | MRK_W | Popped marker |
| fill_o | output | CW | Number of stored elements |
| full_o | output | 1 | Fill level equals the effective depth |
| empty_o | output | 1 | Fill level is zero |
| wm_irq_o | output | 1 | Watermark interrupt pulse |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Every result is due exactly one clock edge after the cycle whose inputs cause it. This covers the new fill level, the full and empty flags, the popped element with its valid strobe, the watermark pulse and the overflow flag. The bench drives each cycle's inputs shortly after a rising edge and samples all outputs 1 ns after the next rising edge, so each comparison lines up with the register stage that produces it. A running model of depth, order, watermark and overflow is updated at that same boundary. The sweep covers several depths, including the clamped ones, and fills past full, mixes pushes and pops, and drains past empty at each depth.

// File: rtl/txevt_pkg.sv
package txevt_pkg;

  // Operation on the log in one cycle, encoded as {pop, push}.
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

endpackage

// File: rtl/txevt_cfg.sv
// Maps the configured depth onto the legal range 1..DEPTH.
module txevt_cfg #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input  logic [CW-1:0] size_i,
  output logic [CW-1:0] size_o
);

  localparam logic [CW-1:0] MAX_SZ = CW'(DEPTH);

  always_comb begin
    if (size_i == '0) begin
      size_o = CW'(1);
    end else if (size_i > MAX_SZ) begin
      size_o = MAX_SZ;
    end else begin
      size_o = size_i;
    end
  end

endmodule

// File: rtl/txevt_ptr.sv
// Index and fill-level control. Indices wrap at the effective depth.
module txevt_ptr
  import txevt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] size_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_idx_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_idx_o,
  output logic [CW-1:0] fill_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] fill_nxt_o,
  output logic          grow_o,
  output logic          drop_o
);

  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_n;
  logic [AW-1:0] wr_q;
  logic [AW-1:0] rd_q;
  logic [AW-1:0] last_idx;
  logic          full_q;
  logic          empty_q;
  logic          do_pop;
  logic          do_push;
  fifo_op_e      op;

  assign last_idx = AW'(size_i - CW'(1));
  assign do_pop   = pop_i && (fill_q != '0);
  // A full log still accepts a push when a pop frees a slot in the same cycle.
  assign do_push  = push_i && ((fill_q < size_i) || do_pop);
  assign op       = fifo_op_e'({do_pop, do_push});

  always_comb begin
    case (op)
      OP_PUSH: fill_n = fill_q + CW'(1);
      OP_POP:  fill_n = fill_q - CW'(1);
      default: fill_n = fill_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q  <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      fill_q  <= fill_n;
      full_q  <= (fill_n == size_i);
      empty_q <= (fill_n == '0);
      if (do_push) begin
        wr_q <= (wr_q == last_idx) ? '0 : wr_q + AW'(1);
      end
      if (do_pop) begin
        rd_q <= (rd_q == last_idx) ? '0 : rd_q + AW'(1);
      end
    end
  end

  assign wr_en_o    = do_push;
  assign wr_idx_o   = wr_q;
  assign rd_en_o    = do_pop;
  assign rd_idx_o   = rd_q;
  assign fill_o     = fill_q;
  assign full_o     = full_q;
  assign empty_o    = empty_q;
  assign fill_nxt_o = fill_n;
  assign grow_o     = (op == OP_PUSH);
  assign drop_o     = push_i && !do_push;

endmodule

// File: rtl/txevt_ram.sv
// Simple dual-port storage with a registered read (block RAM friendly).
module txevt_ram #(
  parameter int W     = 53,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem [DEPTH];

  // Read-first: a read and a write to the same slot return the old word.
  always_ff @(posedge clk) begin
    if (re_i) begin
      rdata_o <= mem[raddr_i];
    end
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

endmodule

// File: rtl/txevt_flags.sv
// Watermark pulse and sticky overflow flag.
module txevt_flags #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] wm_i,
  input  logic [CW-1:0] fill_nxt_i,
  input  logic          grow_i,
  input  logic          drop_i,
  input  logic          clr_i,
  output logic          wm_irq_o,
  output logic          ovf_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wm_irq_o <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      wm_irq_o <= (wm_i != '0) && grow_i && (fill_nxt_i == wm_i);
      if (drop_i) begin
        ovf_o <= 1'b1;
      end else if (clr_i) begin
        ovf_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/txevt_log.sv
module txevt_log #(
  parameter  int ID_W  = 29,
  parameter  int TS_W  = 16,
  parameter  int MRK_W = 8,
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int EW    = ID_W + TS_W + MRK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cfg_size_i,
  input  logic [CW-1:0]    cfg_wm_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic             done_i,
  input  logic [ID_W-1:0]  done_id_i,
  input  logic [MRK_W-1:0] done_mrk_i,
  input  logic             pop_i,
  input  logic             ovf_clr_i,
  output logic             rd_vld_o,
  output logic [ID_W-1:0]  rd_id_o,
  output logic [TS_W-1:0]  rd_ts_o,
  output logic [MRK_W-1:0] rd_mrk_o,
  output logic [CW-1:0]    fill_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             wm_irq_o,
  output logic             ovf_o
);

  logic [CW-1:0] size_eff;
  logic          wr_en;
  logic          rd_en;
  logic [AW-1:0] wr_idx;
  logic [AW-1:0] rd_idx;
  logic [CW-1:0] fill_nxt;
  logic          grow;
  logic          drop;
  logic [EW-1:0] wr_word;
  logic [EW-1:0] rd_word;

  txevt_cfg #(.DEPTH(DEPTH), .CW(CW)) u_cfg (
    .size_i (cfg_size_i),
    .size_o (size_eff)
  );

  txevt_ptr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .push_i     (done_i),
    .pop_i      (pop_i),
    .size_i     (size_eff),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .rd_en_o    (rd_en),
    .rd_idx_o   (rd_idx),
    .fill_o     (fill_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .fill_nxt_o (fill_nxt),
    .grow_o     (grow),
    .drop_o     (drop)
  );

  assign wr_word = {done_id_i, ts_i, done_mrk_i};

  txevt_ram #(.W(EW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_idx),
    .wdata_i (wr_word),
    .re_i    (rd_en),
    .raddr_i (rd_idx),
    .rdata_o (rd_word)
  );

  txevt_flags #(.CW(CW)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .wm_i       (cfg_wm_i),
    .fill_nxt_i (fill_nxt),
    .grow_i     (grow),
    .drop_i     (drop),
    .clr_i      (ovf_clr_i),
    .wm_irq_o   (wm_irq_o),
    .ovf_o      (ovf_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_o <= 1'b0;
    end else begin
      rd_vld_o <= rd_en;
    end
  end

  assign rd_id_o  = rd_word[EW-1 -: ID_W];
  assign rd_ts_o  = rd_word[MRK_W +: TS_W];
  assign rd_mrk_o = rd_word[MRK_W-1:0];

endmodule

// File: rtl/txevt_log_chk.sv
module txevt_log_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          done_i,
  input logic          pop_i,
  input logic          ovf_clr_i,
  input logic [CW-1:0] cfg_wm_i,
  input logic [CW-1:0] size_eff,
  input logic [CW-1:0] fill_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          rd_vld_o,
  input logic          wm_irq_o,
  input logic          ovf_o
);

  a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
    done_i && !pop_i && !full_o |=> fill_o == $past(fill_o) + CW'(1));

  a_r3_pop_returns: assert property (@(posedge clk) disable iff (rst)
    pop_i && !empty_o |=> rd_vld_o);

  a_r4_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill_o <= size_eff);

  a_r4_full_flag: assert property (@(posedge clk) disable iff (rst)
    full_o == (fill_o == size_eff));

  a_r6_both_keep: assert property (@(posedge clk) disable iff (rst)
    done_i && pop_i && !empty_o |=> fill_o == $past(fill_o) && !$rose(ovf_o));

  a_r7_drop_full: assert property (@(posedge clk) disable iff (rst)
    done_i && full_o && !pop_i |=> ovf_o && fill_o == $past(fill_o));

  a_r8_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop_i && empty_o |=> !rd_vld_o);

  a_r9_wm_level: assert property (@(posedge clk) disable iff (rst)
    wm_irq_o |-> fill_o == $past(cfg_wm_i) && cfg_wm_i != '0 && fill_o > $past(fill_o));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_o && !ovf_clr_i |=> ovf_o);

endmodule

bind txevt_log txevt_log_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done_i    (done_i),
  .pop_i     (pop_i),
  .ovf_clr_i (ovf_clr_i),
  .cfg_wm_i  (cfg_wm_i),
  .size_eff  (size_eff),
  .fill_o    (fill_o),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .rd_vld_o  (rd_vld_o),
  .wm_irq_o  (wm_irq_o),
  .ovf_o     (ovf_o)
);

// File: tb/sim_txevt_log.sv
`timescale 1ns/1ps
module sim_txevt_log;

  localparam int ID_W  = 29;
  localparam int TS_W  = 16;
  localparam int MRK_W = 8;
  localparam int DEPTH = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CW-1:0]    cfg_size = CW'(4);
  logic [CW-1:0]    cfg_wm = '0;
  logic [TS_W-1:0]  ts = '0;
  logic             done = 1'b0;
  logic [ID_W-1:0]  done_id = '0;
  logic [MRK_W-1:0] done_mrk = '0;
  logic             pop = 1'b0;
  logic             ovf_clr = 1'b0;
  logic             rd_vld;
  logic [ID_W-1:0]  rd_id;
  logic [TS_W-1:0]  rd_ts;
  logic [MRK_W-1:0] rd_mrk;
  logic [CW-1:0]    fill;
  logic             full;
  logic             empty;
  logic             wm_irq;
  logic             ovf;

  always #2 clk = ~clk;

  txevt_log #(.ID_W(ID_W), .TS_W(TS_W), .MRK_W(MRK_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cfg_size_i(cfg_size), .cfg_wm_i(cfg_wm), .ts_i(ts),
    .done_i(done), .done_id_i(done_id), .done_mrk_i(done_mrk), .pop_i(pop),
    .ovf_clr_i(ovf_clr), .rd_vld_o(rd_vld), .rd_id_o(rd_id), .rd_ts_o(rd_ts),
    .rd_mrk_o(rd_mrk), .fill_o(fill), .full_o(full), .empty_o(empty),
    .wm_irq_o(wm_irq), .ovf_o(ovf)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // Reference model
  logic [ID_W-1:0]  m_id  [64];
  logic [TS_W-1:0]  m_ts  [64];
  logic [MRK_W-1:0] m_mrk [64];
  int mh = 0;
  int mt = 0;
  int mfill = 0;
  bit movf = 1'b0;
  int seq = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_size(input int c);
    if (c == 0) return 1;
    if (c > DEPTH) return DEPTH;
    return c;
  endfunction

  task automatic cyc(input bit d, input bit p, input bit clr);
    int s;
    bit do_pop;
    bit do_push;
    bit drop;
    bit exp_wm;
    int old_fill;
    logic [ID_W-1:0]  e_id;
    logic [TS_W-1:0]  e_ts;
    logic [MRK_W-1:0] e_mrk;
    string tag;
    s        = eff_size(int'(cfg_size));
    done     = d;
    pop      = p;
    ovf_clr  = clr;
    done_id  = ID_W'(seq * 977 + 11);
    done_mrk = MRK_W'(seq * 5 + 1);
    old_fill = mfill;
    do_pop   = p && (mfill > 0);
    do_push  = d && ((mfill < s) || do_pop);
    drop     = d && !do_push;
    e_id  = m_id[mh % 64];
    e_ts  = m_ts[mh % 64];
    e_mrk = m_mrk[mh % 64];
    if (do_pop) begin
      mh++;
      mfill--;
    end
    if (do_push) begin
      m_id[mt % 64]  = done_id;
      m_ts[mt % 64]  = ts;
      m_mrk[mt % 64] = done_mrk;
      mt++;
      mfill++;
      seq++;
    end
    if (drop) movf = 1'b1;
    else if (clr) movf = 1'b0;
    exp_wm = (cfg_wm != '0) && (mfill > old_fill) && (mfill == int'(cfg_wm));
    if (drop) tag = "R7";
    else if (do_push && do_pop) tag = "R6";
    else if (d && p) tag = "R8";
    else if (do_push) tag = "R2";
    else if (p && !do_pop) tag = "R8";
    else tag = "R3";
    @(posedge clk);
    #1;
    ts = ts + TS_W'(1);
    chk(int'(fill) == mfill, tag, fill, mfill);
    chk(rd_vld == do_pop, do_pop ? "R3" : "R8", rd_vld, do_pop);
    if (do_pop) begin
      chk(rd_id == e_id, "R3 id R5", rd_id, e_id);
      chk(rd_ts == e_ts, "R3 ts R5", rd_ts, e_ts);
      chk(rd_mrk == e_mrk, "R3 marker R5", rd_mrk, e_mrk);
    end
    chk(full == (mfill == s), "R4 full", full, mfill == s);
    chk(empty == (mfill == 0), "R4 empty", empty, mfill == 0);
    chk(wm_irq == exp_wm, "R9 watermark", wm_irq, exp_wm);
    chk(ovf == movf, clr ? "R10 clear" : "R7 R10 overflow", ovf, movf);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int sizes [8] = '{1, 2, 3, 5, 8, 32, 0, 40};
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, during and after reset
    chk(fill == '0, "R1 fill", fill, 0);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(rd_vld == 1'b0 && wm_irq == 1'b0 && ovf == 1'b0, "R1 strobes", {rd_vld, wm_irq, ovf}, 0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk(fill == '0 && empty && !full && !ovf, "R1 after release", fill, 0);

    foreach (sizes[k]) begin
      int s;
      cfg_size = CW'(sizes[k]);
      s = eff_size(sizes[k]);
      if (k == 2) cfg_wm = '0;
      else if (k % 2 == 1) cfg_wm = CW'(s);
      else cfg_wm = CW'((s + 1) / 2);
      cyc(0, 0, 0);
      // Fill past full: R2, then R7 drops; set-versus-clear in one cycle for R10
      for (int i = 0; i < s + 2; i++) cyc(1, 0, (i == s + 1));
      // R6 on a full log
      cyc(1, 1, 0);
      for (int i = 0; i < s / 2 + 1; i++) cyc(0, 1, 0);
      // Mixed traffic for wrap coverage (R5)
      for (int i = 0; i < 3 * s + 4; i++) cyc(i % 3 != 1, i % 3 != 0, 0);
      // Drain past empty (R8)
      for (int i = 0; i < s + 3; i++) cyc(0, 1, 0);
      cyc(1, 1, 0);
      cyc(0, 1, 0);
      // R10 clear
      cyc(0, 0, 1);
      cyc(0, 0, 0);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule